// File: doc/BRIEF.md
# Three-Wire RF Register Serializer

This block sends one register write to an external radio transceiver over a three-line serial link: a serial clock, a serial data line and a latch-enable line. The caller presents a chip-type code, a 5-bit register address and a 16-bit data word, then pulses `start`. The block packs these into a frame. The frame's length, bit order and field layout are set by the chip type. The block then clocks the frame out one bit at a time and pulses the enable line once the last bit is in.

One chip type needs its fields scrambled before shifting. Each nibble is bit-reversed and the nibbles are placed in a fixed order. Chip codes that have no frame format are rejected at once. Software that would poll a busy bit with a timeout sees that bit here as the registered `busy` output. A one-cycle `done` pulse marks completion.

Top module: `rf3w_serializer`

## Requirements
- R1: Chip code 0 sends a 16-bit frame, most-significant bit first, laid out as {data[11:0], addr[3:0]}.
- R2: Chip code 1 sends a 32-bit frame, least-significant bit first, laid out as {10'b0, data[15:0], addr[4:0], 1'b1}; the write-enable bit at bit 0 is always 1 and goes out first.
- R3: Chip code 2 sends a 22-bit frame, most-significant bit first, laid out as {1'b0, addr[4:0], data[15:0]}.
- R4: Chip code 3 sends a 28-bit frame, most-significant bit first, with each 4-bit group bit-reversed (rev(b3 b2 b1 b0) = b0 b1 b2 b3). rev(data[11:8]) goes to [3:0], rev(data[7:4]) to [7:4], rev(data[3:0]) to [11:8], rev(addr[4:1]) to [15:12], addr[0] to [16], zeros to [23:17], and rev(data[15:12]) to [27:24].
- R5: For each bit, the data line is set while the serial clock is low for HALF_CYC cycles. The clock is then high for HALF_CYC cycles, and data does not change while the clock is high.
- R6: The enable line stays low while bits shift. It rises only after the last clock falls, stays high for HALF_CYC cycles, then returns low.
- R7: `busy` rises in the cycle after an accepted start. It falls in the same cycle that `done` is high, and `done` is high for exactly one cycle.
- R8: A start pulse seen while `busy` is high has no effect: the frame in flight is unchanged and no second transfer follows.
- R9: Chip codes 4 to 7 are rejected. `err` is high for one cycle after the start, `busy` stays low and no clock edge is produced.
- R10: After reset, `sclk`, `senable`, `busy`, `done` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send one write |
| chipSel | input | 3 | Chip-type code |
| regAddr | input | 5 | Target register address |
| regData | input | 16 | Value to write |
| sclk | output | 1 | Serial clock to the transceiver |
| sdata | output | 1 | Serial data to the transceiver |
| senable | output | 1 | Latch enable, pulsed after the frame |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| err | output | 1 | One-cycle pulse for a rejected chip code |

## Verification
The assertions assume that `start` is a clean synchronous level. They also assume that `chipSel`, `regAddr` and `regData` are valid in the cycle `start` is sampled. The block copies the frame into its shift register at that edge, so these inputs are free to change afterwards. The bench drives every input on the falling clock edge, holds `start` for exactly one cycle, and waits for `done` before it issues the next request. The one exception is the deliberate mid-transfer start used to check R8.

// File: rtl/rf3w_pkg.sv
`timescale 1ns/1ps
package rf3w_pkg;
  localparam int FRAME_MAX = 32;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef enum logic [2:0] {
    CHIP_A = 3'd0,
    CHIP_B = 3'd1,
    CHIP_C = 3'd2,
    CHIP_S = 3'd3
  } chip_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shift;
  } rf3w_strobe_t;

  function automatic logic [3:0] nibRev(input logic [3:0] n);
    return {n[0], n[1], n[2], n[3]};
  endfunction
endpackage

// File: rtl/rf3w_packer.sv
`timescale 1ns/1ps
module rf3w_packer
  import rf3w_pkg::*;
(
  input  logic [2:0]           chipSel,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regData,
  output logic [FRAME_MAX-1:0] frameWord,
  output logic [CNT_W-1:0]     frameLen,
  output logic                 lsbFirst,
  output logic                 typeOk
);
  always_comb begin
    frameWord = '0;
    frameLen  = '0;
    lsbFirst  = 1'b0;
    typeOk    = 1'b1;
    case (chipSel)
      CHIP_A: begin
        frameWord = {16'b0, regData[11:0], regAddr[3:0]};
        frameLen  = CNT_W'(16);
      end
      CHIP_B: begin
        frameWord = {10'b0, regData, regAddr, 1'b1};
        frameLen  = CNT_W'(32);
        lsbFirst  = 1'b1;
      end
      CHIP_C: begin
        frameWord = {11'b0, regAddr, regData};
        frameLen  = CNT_W'(22);
      end
      CHIP_S: begin
        frameWord = {4'b0, nibRev(regData[15:12]), 7'b0, regAddr[0],
                     nibRev(regAddr[4:1]), nibRev(regData[3:0]),
                     nibRev(regData[7:4]), nibRev(regData[11:8])};
        frameLen  = CNT_W'(28);
      end
      default: typeOk = 1'b0;
    endcase
  end
endmodule

// File: rtl/rf3w_datapath.sv
`timescale 1ns/1ps
module rf3w_datapath
  import rf3w_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  rf3w_strobe_t         strb,
  input  logic [FRAME_MAX-1:0] frameWord,
  input  logic [CNT_W-1:0]     frameLen,
  input  logic                 lsbFirst,
  output logic                 sdata
);
  logic [FRAME_MAX-1:0] revWord;
  logic [FRAME_MAX-1:0] txOrder;
  logic [FRAME_MAX-1:0] shiftReg;
  logic [CNT_W-1:0]     dropBits;

  // full-width mirror, then drop the unused low bits so bit 0 is sent first
  for (genvar i = 0; i < FRAME_MAX; i++) begin : g_rev
    assign revWord[i] = frameWord[FRAME_MAX-1-i];
  end

  assign dropBits = CNT_W'(FRAME_MAX) - frameLen;
  assign txOrder  = lsbFirst ? frameWord : (revWord >> dropBits);

  always_ff @(posedge clk) begin
    if (!rstN)            shiftReg <= '0;
    else if (strb.load)   shiftReg <= txOrder;
    else if (strb.shift)  shiftReg <= shiftReg >> 1;
  end

  assign sdata = shiftReg[0];
endmodule

// File: rtl/rf3w_ctrl.sv
`timescale 1ns/1ps
module rf3w_ctrl
  import rf3w_pkg::*;
#(
  parameter int HALF_CYC = 200
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             typeOk,
  input  logic [CNT_W-1:0] frameLen,
  output rf3w_strobe_t     strb,
  output logic             sclk,
  output logic             senable,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int TMR_W = $clog2(HALF_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_HIGH, ST_LATCH} state_e;

  state_e           state;
  logic [TMR_W-1:0] timer;
  logic [CNT_W-1:0] bitsLeft;
  logic             phaseEnd;
  logic             accept;

  assign phaseEnd = (timer == TMR_W'(HALF_CYC - 1));
  assign accept   = (state == ST_IDLE) && start && typeOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      timer    <= '0;
      bitsLeft <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          timer <= '0;
          if (start && typeOk) begin
            state    <= ST_SETUP;
            busy     <= 1'b1;
            bitsLeft <= frameLen;
          end else if (start) begin
            err <= 1'b1;
          end
        end
        ST_SETUP: begin
          if (phaseEnd) begin
            timer <= '0;
            state <= ST_HIGH;
          end else timer <= timer + 1'b1;
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            timer    <= '0;
            bitsLeft <= bitsLeft - 1'b1;
            state    <= (bitsLeft == CNT_W'(1)) ? ST_LATCH : ST_SETUP;
          end else timer <= timer + 1'b1;
        end
        ST_LATCH: begin
          if (phaseEnd) begin
            timer <= '0;
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else timer <= timer + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load  = accept;
    strb.shift = (state == ST_HIGH) && phaseEnd;
  end

  assign sclk    = (state == ST_HIGH);
  assign senable = (state == ST_LATCH);
endmodule

// File: rtl/rf3w_serializer.sv
`timescale 1ns/1ps
module rf3w_serializer
  import rf3w_pkg::*;
#(
  parameter int HALF_CYC = 200
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  chipSel,
  input  logic [4:0]  regAddr,
  input  logic [15:0] regData,
  output logic        sclk,
  output logic        sdata,
  output logic        senable,
  output logic        busy,
  output logic        done,
  output logic        err
);
  rf3w_strobe_t         strb;
  logic [FRAME_MAX-1:0] frameWord;
  logic [CNT_W-1:0]     frameLen;
  logic                 lsbFirst;
  logic                 typeOk;

  rf3w_packer u_pack (
    .chipSel(chipSel), .regAddr(regAddr), .regData(regData),
    .frameWord(frameWord), .frameLen(frameLen),
    .lsbFirst(lsbFirst), .typeOk(typeOk)
  );

  rf3w_ctrl #(.HALF_CYC(HALF_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .typeOk(typeOk),
    .frameLen(frameLen), .strb(strb), .sclk(sclk), .senable(senable),
    .busy(busy), .done(done), .err(err)
  );

  rf3w_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .frameWord(frameWord),
    .frameLen(frameLen), .lsbFirst(lsbFirst), .sdata(sdata)
  );
endmodule

// File: rtl/rf3w_serializer_chk.sv
`timescale 1ns/1ps
module rf3w_serializer_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic sclk,
  input logic sdata,
  input logic senable,
  input logic busy,
  input logic done,
  input logic err
);
  // R5: data held while the serial clock is high
  a_r5_data_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(sdata));
  // R5: clock only toggles inside a transfer
  a_r5_clock_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> busy);
  // R6: enable and clock never high together
  a_r6_enable_clock_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    senable |-> !sclk);
  // R6: enable pulse follows the last clock fall directly
  a_r6_enable_after_clock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(senable) |-> $past(sclk));
  // R7: busy falls exactly with done
  a_r7_fall_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R7: done lasts one cycle and is never high while busy
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy ##1 !done));
  // R8: a start during a transfer does not end it early
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !senable) |=> busy);
  // R9: a rejection never coincides with a transfer starting
  a_r9_err_idle: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !busy);
endmodule

bind rf3w_serializer rf3w_serializer_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .sclk(sclk), .sdata(sdata),
  .senable(senable), .busy(busy), .done(done), .err(err)
);

// File: tb/sim_rf3w_serializer.sv
`timescale 1ns/1ps
module sim_rf3w_serializer;
  localparam int HALF = 3;
  localparam int NVEC = 8;
  // {chip code, address, data}
  localparam logic [23:0] VEC [NVEC] = '{
    {3'd0, 5'h0A, 16'hFABC},
    {3'd0, 5'h13, 16'h0001},
    {3'd1, 5'h1F, 16'hA5C3},
    {3'd1, 5'h00, 16'h8000},
    {3'd2, 5'h11, 16'h1234},
    {3'd2, 5'h0E, 16'hFFFF},
    {3'd3, 5'h03, 16'h1234},
    {3'd3, 5'h1C, 16'hBEEF}
  };

  logic clk = 0, rstN = 0, start = 0;
  logic [2:0] chipSel = '0;
  logic [4:0] regAddr = '0;
  logic [15:0] regData = '0;
  logic sclk, sdata, senable, busy, done, err;

  int checks = 0, errors = 0;
  logic cap [64];
  int capN = 0, enaBad = 0, enaAt = -1, hiBad = 0, loBad = 0;
  longint tRise = 0, tFall = 0;

  rf3w_serializer #(.HALF_CYC(HALF)) u0 (.*);

  always #5 clk = ~clk;

  always @(posedge sclk) begin
    if (capN < 64) cap[capN] = sdata;
    if (senable) enaBad++;
    if (capN > 0 && ($time - tFall) != HALF * 10) loBad++;
    tRise = $time;
    capN++;
  end
  always @(negedge sclk) begin
    if (($time - tRise) != HALF * 10) hiBad++;
    tFall = $time;
  end
  always @(posedge senable) enaAt = capN;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expLen(input logic [2:0] t);
    case (t) 3'd0: return 16; 3'd1: return 32; 3'd2: return 22; default: return 28; endcase
  endfunction

  function automatic logic [3:0] rv(input logic [3:0] n);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = n[3-i];
    return r;
  endfunction

  function automatic logic [31:0] expFrame(input logic [2:0] t, input logic [4:0] a,
                                           input logic [15:0] d);
    logic [31:0] f = '0;
    case (t)
      3'd0: f[15:0] = {d[11:0], a[3:0]};
      3'd1: f = {10'b0, d, a, 1'b1};
      3'd2: f[21:0] = {1'b0, a, d};
      default: begin
        f[3:0] = rv(d[11:8]); f[7:4] = rv(d[7:4]); f[11:8] = rv(d[3:0]);
        f[15:12] = rv(a[4:1]); f[16] = a[0]; f[27:24] = rv(d[15:12]);
      end
    endcase
    return f;
  endfunction

  function automatic logic [31:0] rebuild(input logic [2:0] t);
    logic [31:0] f = '0;
    int n = expLen(t);
    for (int i = 0; i < n; i++)
      if (t == 3'd1) f[i] = cap[i]; else f[n-1-i] = cap[i];
    return f;
  endfunction

  task automatic launch(input logic [2:0] t, input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    capN = 0; enaAt = -1; enaBad = 0;
    chipSel = t; regAddr = a; regData = d; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic waitDone(output bit seen);
    seen = 0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    string tag;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 sclk", sclk, 0); chk("R10 senable", senable, 0);
    chk("R10 busy", busy, 0); chk("R10 done", done, 0); chk("R10 err", err, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] t = VEC[v][23:21];
      logic [4:0] a = VEC[v][20:16];
      logic [15:0] d = VEC[v][15:0];
      tag = (t == 0) ? "R1" : (t == 1) ? "R2" : (t == 2) ? "R3" : "R4";
      launch(t, a, d);
      chk("R7 busy after start", busy, 1);
      waitDone(seen);
      chk("R7 done seen", seen, 1);
      chk("R7 busy clear with done", busy, 0);
      chk({tag, " bit count"}, capN, expLen(t));
      chk({tag, " frame"}, rebuild(t), expFrame(t, a, d));
      chk("R6 enable low while shifting", enaBad, 0);
      chk("R6 enable after last bit", enaAt, expLen(t));
      @(negedge clk);
      chk("R7 done one cycle", done, 0);
    end
    chk("R5 clock high width", hiBad, 0);
    chk("R5 clock low width", loBad, 0);

    // R4 hand-computed scrambled frame
    launch(3'd3, 5'h03, 16'h1234);
    waitDone(seen);
    chk("R4 literal frame", rebuild(3'd3), 32'h080182C4);

    // R8 start while busy is ignored
    launch(3'd1, 5'h05, 16'h5A5A);
    repeat (20) @(negedge clk);
    chipSel = 3'd0; regAddr = 5'h1F; regData = 16'hFFFF; start = 1;
    @(negedge clk); start = 0;
    waitDone(seen);
    chk("R8 frame unchanged", rebuild(3'd1), expFrame(3'd1, 5'h05, 16'h5A5A));
    chk("R8 bit count unchanged", capN, 32);
    repeat (6) @(negedge clk);
    chk("R8 no second transfer", busy, 0);
    chk("R8 no extra clocks", capN, 32);

    // R9 unsupported codes
    for (int c = 4; c < 8; c++) begin
      launch(3'(c), 5'h01, 16'h0F0F);
      chk("R9 err pulse", err, 1);
      chk("R9 busy stays low", busy, 0);
      @(negedge clk);
      chk("R9 err one cycle", err, 0);
      repeat (4) @(negedge clk);
      chk("R9 no clock edges", capN, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule